// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave side of a two-wire serial memory. The clock and data lines reach it already synchronized to the system clock. It drives only an open-drain pull-down enable for the data line. It finds start and stop conditions on the bus and compares the device select byte with three strap inputs. Write commands carry a two-byte word address. Read data comes from a byte-wide memory read port, and received write data goes out to a separate page-buffer block. A busy input from that block tells the controller that an internal programming cycle is running. While busy, the controller refuses to be selected, so a master can find the end of programming by polling.

The controller keeps one address pointer across transfers. It supports three reads. A current-address read needs no address phase. A random read sends a write command that carries only the word address, then a repeated start and a read select. A sequential read continues for as long as the master acknowledges. The pointer wraps from the top of the array to zero during reads. During writes it wraps inside a page.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset, and until the first start condition, the block ignores the bus and never pulls the data line low. A start condition at any point aborts the transfer in progress and begins a new select byte. A stop condition returns the block to idle.
- R2: The select byte arrives MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal strap_i[2:0]. Bit 0 is 1 for a read and 0 for a write. On any mismatch the block gives no acknowledge and ignores the bus until the next start or stop.
- R3: The block acknowledges each byte it accepts. It asserts sda_oe_o after the falling clock edge that ends the eighth bit and releases it after the falling edge of the ninth clock.
- R4: While busy_i is high, a matching select byte gets no acknowledge. Once busy_i is low, the same select byte is acknowledged.
- R5: After a write select, two word-address bytes follow, high byte first. Address bits at and above log2(MEM_BYTES) are ignored.
- R6: Each data byte after the word address is acknowledged and presented for one cycle on wr_valid_o, wr_addr_o and wr_data_o. The next byte's address increments only the low log2(PAGE_BYTES) bits, which wrap within the page.
- R7: wr_commit_o pulses for one cycle after a stop condition, but only when at least one data byte was received since the previous stop. A write that carries only the word address produces no pulse.
- R8: A current-address read returns the byte at the address after the last byte read or written.
- R9: A write select with word address, followed by a repeated start and a read select, returns the byte at the loaded address.
- R10: During a read, each master acknowledge (data low in the ninth clock) causes the next byte to be sent. The address wraps from MEM_BYTES-1 to 0.
- R11: After a master non-acknowledge, the block releases the data line and ignores the bus until the next start or stop.
- R12: sda_oe_o changes only while SCL is low. Read data bits go out MSB first, each placed after a falling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Device select strap bits, compared with select bits 3..1 |
| busy_i | input | 1 | Programming cycle in progress |
| mem_raddr_o | output | AW | Memory read address (the pointer) |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after the address |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | AW | Array address of the received data byte |
| wr_data_o | output | 8 | Received data byte |
| wr_commit_o | output | 1 | One-cycle pulse: start programming the collected bytes |

## Verification
Some rules are checked by assertions on every cycle. The pull-down must never assert while SCL is high. A select decision made while busy, or with the wrong strap bits, must leave the line released. The idle state must never drive the bus. Write strobes may come only from the data phase, and commit pulses only from a stop. The bench scenarios are needed for the rest. They show select and address sequencing, in-page wrap of write addresses, pointer continuity between transfers, full-array wrap in sequential reads, the start-abort in mid-byte, and acknowledge polling that ends when programming finishes.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } tw_state_e;

  localparam logic [3:0] SEL_PREFIX = 4'b1010;
  localparam logic [3:0] CNT_ACK_SLOT = 4'd8;
  localparam logic [3:0] CNT_OWN_ACK = 4'd9;
endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_full_i,
  input  logic          inc_page_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic [PW-1:0] page_off;

  assign page_off = ptr_q[PW-1:0] + {{(PW-1){1'b0}}, 1'b1};

  always_comb begin
    ptr_d = ptr_q;
    if (load_i)          ptr_d = load_val_i;
    else if (inc_full_i) ptr_d = ptr_q + {{(AW-1){1'b0}}, 1'b1};
    else if (inc_page_i) ptr_d = {ptr_q[AW-1:PW], page_off};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int MEM_BYTES  = 4096,
  parameter int PAGE_BYTES = 32,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [2:0]    strap_i,
  input  logic          busy_i,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o
);
  logic rst_sync_n;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  tw_state_e     state_q, state_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [7:0]    hi_q, hi_d;
  logic          oe_q, oe_d;
  logic          mack_q, mack_d;
  logic          wrote_q, wrote_d;
  logic          wr_valid_q, wr_valid_d;
  logic [AW-1:0] wr_addr_q, wr_addr_d;
  logic [7:0]    wr_data_q, wr_data_d;
  logic          commit_q, commit_d;

  logic          ptr_load, ptr_inc_full, ptr_inc_page;
  logic [AW-1:0] ptr_q, ptr_load_val;
  logic          sel_hit;

  tw_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tw_bus_events u_ev (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  tw_addr_ptr #(.AW(AW), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n),
    .load_i(ptr_load), .load_val_i(ptr_load_val),
    .inc_full_i(ptr_inc_full), .inc_page_i(ptr_inc_page),
    .ptr_o(ptr_q)
  );

  assign ptr_load_val = AW'({hi_q, shreg_q});
  assign sel_hit      = (shreg_q[7:4] == SEL_PREFIX) && (shreg_q[3:1] == strap_i);

  // next-state logic
  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    shreg_d      = shreg_q;
    hi_d         = hi_q;
    oe_d         = oe_q;
    mack_d       = mack_q;
    wrote_d      = wrote_q;
    wr_valid_d   = 1'b0;
    wr_addr_d    = wr_addr_q;
    wr_data_d    = wr_data_q;
    commit_d     = 1'b0;
    ptr_load     = 1'b0;
    ptr_inc_full = 1'b0;
    ptr_inc_page = 1'b0;

    if (start_evt) begin
      state_d = ST_SEL;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_evt) begin
      state_d  = ST_IDLE;
      cnt_d    = '0;
      oe_d     = 1'b0;
      commit_d = wrote_q;
      wrote_d  = 1'b0;
    end else if (state_q != ST_IDLE && cnt_q == CNT_OWN_ACK) begin
      // ninth clock driven by this block; leave it on the falling edge
      if (scl_fall) begin
        cnt_d = '0;
        oe_d  = 1'b0;
        if (state_q == ST_RDAT) begin
          shreg_d      = mem_rdata_i;
          oe_d         = ~mem_rdata_i[7];
          ptr_inc_full = 1'b1;
        end
      end
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_RDAT: begin
          if (scl_rise && cnt_q == CNT_ACK_SLOT) mack_d = ~sda_i;
          if (scl_fall) begin
            if (cnt_q < 4'd7) begin
              shreg_d = {shreg_q[6:0], 1'b0};
              oe_d    = ~shreg_q[6];
              cnt_d   = cnt_q + 4'd1;
            end else if (cnt_q == 4'd7) begin
              oe_d  = 1'b0;
              cnt_d = CNT_ACK_SLOT;
            end else if (mack_q) begin
              shreg_d      = mem_rdata_i;
              oe_d         = ~mem_rdata_i[7];
              ptr_inc_full = 1'b1;
              cnt_d        = '0;
            end else begin
              state_d = ST_IDLE;
              cnt_d   = '0;
            end
          end
        end
        default: begin
          if (scl_rise && cnt_q < CNT_ACK_SLOT) begin
            shreg_d = {shreg_q[6:0], sda_i};
            cnt_d   = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == CNT_ACK_SLOT) begin
            cnt_d = CNT_OWN_ACK;
            oe_d  = 1'b1;
            unique case (state_q)
              ST_SEL: begin
                if (sel_hit && !busy_i) begin
                  state_d = shreg_q[0] ? ST_RDAT : ST_AHI;
                end else begin
                  oe_d    = 1'b0;
                  cnt_d   = '0;
                  state_d = ST_IDLE;
                end
              end
              ST_AHI: begin
                hi_d    = shreg_q;
                state_d = ST_ALO;
              end
              ST_ALO: begin
                ptr_load = 1'b1;
                state_d  = ST_WDAT;
              end
              default: begin
                wr_valid_d   = 1'b1;
                wr_addr_d    = ptr_q;
                wr_data_d    = shreg_q;
                wrote_d      = 1'b1;
                ptr_inc_page = 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      hi_q       <= '0;
      oe_q       <= 1'b0;
      mack_q     <= 1'b0;
      wrote_q    <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      commit_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      shreg_q    <= shreg_d;
      hi_q       <= hi_d;
      oe_q       <= oe_d;
      mack_q     <= mack_d;
      wrote_q    <= wrote_d;
      wr_valid_q <= wr_valid_d;
      wr_addr_q  <= wr_addr_d;
      wr_data_q  <= wr_data_d;
      commit_q   <= commit_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_raddr_o = ptr_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign wr_commit_o = commit_q;
endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk
  import tw_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       busy_i,
  input logic [2:0] strap_i,
  input tw_state_e  state_q,
  input logic [3:0] cnt_q,
  input logic [7:0] shreg_q,
  input logic       scl_fall,
  input logic       stop_evt,
  input logic       wr_valid_o,
  input logic       wr_commit_o
);
  logic sel_decide;
  assign sel_decide = (state_q == ST_SEL) && (cnt_q == CNT_ACK_SLOT) && scl_fall;

  a_r12_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

  a_r4_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_decide && busy_i) |=> !sda_oe_o);

  a_r2_strap_mismatch_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_decide && shreg_q[3:1] != strap_i) |=> !sda_oe_o);

  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  a_r6_strobe_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $past(state_q == ST_WDAT));

  a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_evt));
endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy_i(busy_i), .strap_i(strap_i), .state_q(state_q), .cnt_q(cnt_q),
  .shreg_q(shreg_q), .scl_fall(scl_fall), .stop_evt(stop_evt),
  .wr_valid_o(wr_valid_o), .wr_commit_o(wr_commit_o)
);

// File: tb/tb_tw_eeprom_slave.sv
`timescale 1ns/1ps
module tb_tw_eeprom_slave;
  localparam int MEM = 4096;
  localparam int PAGE = 32;
  localparam int AW = 12;
  localparam int Q = 4;
  localparam int BUSY_CYC = 600;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic busy = 1'b0;
  logic [7:0] mem_rdata = 8'h00;
  logic sda_oe, wr_valid, wr_commit;
  logic [AW-1:0] mem_raddr, wr_addr;
  logic [7:0] wr_data;
  wire sda_bus = m_sda & ~sda_oe;

  int n_tests = 0, n_fail = 0, n_commit = 0, busy_cnt = 0, r12_bad = 0;
  int exp_ptr = 0;
  bit done = 1'b0;
  logic [7:0] dev_mem [int];
  logic [7:0] exp_ovl [int];
  int cap_a[$], cap_d[$], pend_a[$], pend_d[$];
  logic prev_oe = 1'b0;

  tw_eeprom_slave #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .busy_i(busy),
    .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] base_val(input int a);
    return 8'((a * 37 + (a >> 5)) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] dev_read(input int a);
    return dev_mem.exists(a) ? dev_mem[a] : base_val(a);
  endfunction
  function automatic logic [7:0] exp_read(input int a);
    return exp_ovl.exists(a) ? exp_ovl[a] : base_val(a);
  endfunction
  function automatic int page_at(input int b, input int i);
    return (b & ~(PAGE - 1)) | ((b + i) & (PAGE - 1));
  endfunction
  function automatic logic [7:0] sel(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  // page-buffer and memory model
  always @(negedge clk) mem_rdata <= dev_read(int'(mem_raddr));
  always @(negedge clk) busy <= (busy_cnt != 0);
  always @(posedge clk) begin
    if (rst_n && wr_valid) begin
      cap_a.push_back(int'(wr_addr)); cap_d.push_back(int'(wr_data));
      pend_a.push_back(int'(wr_addr)); pend_d.push_back(int'(wr_data));
    end
    if (rst_n && wr_commit) begin
      n_commit++;
      foreach (pend_a[i]) dev_mem[pend_a[i]] = 8'(pend_d[i]);
      pend_a.delete(); pend_d.delete();
      busy_cnt = BUSY_CYC;
    end else if (busy_cnt > 0) busy_cnt--;
  end

  // R12 monitor: pull-down may change only with SCL low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && m_scl) r12_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic hw();
    repeat (Q) @(negedge clk);
  endtask
  task automatic send_bit(input logic b);
    m_sda = b; hw(); m_scl = 1'b1; hw(); hw(); m_scl = 1'b0; hw();
  endtask
  task automatic xfer_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); acked = !sda_bus; hw(); m_scl = 1'b0; hw();
  endtask
  task automatic rd_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); d[i] = sda_bus; hw(); m_scl = 1'b0; hw();
    end
    m_sda = !mack; hw(); m_scl = 1'b1; hw(); hw(); m_scl = 1'b0; hw(); m_sda = 1'b1;
  endtask
  task automatic start_c();
    m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); m_sda = 1'b0; hw(); m_scl = 1'b0; hw();
  endtask
  task automatic stop_c();
    m_sda = 1'b0; hw(); m_scl = 1'b1; hw(); m_sda = 1'b1; hw(); hw();
  endtask

  task automatic do_write(input logic [15:0] wa, input int n, input string req);
    bit a, ok;
    int b;
    int ea[$], ed[$];
    b = int'(wa) & (MEM - 1);
    ok = 1'b1;
    cap_a.delete(); cap_d.delete();
    start_c();
    xfer_byte(sel(1'b0), a); ok &= a;
    xfer_byte(wa[15:8], a); ok &= a;
    xfer_byte(wa[7:0], a); ok &= a;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      ea.push_back(page_at(b, i)); ed.push_back(int'(d));
      exp_ovl[page_at(b, i)] = d;
      xfer_byte(d, a); ok &= a;
    end
    stop_c(); hw();
    chk(ok, req, "every write byte acknowledged (R3)", int'(ok), 1);
    chk(cap_a.size() == n, req, "write strobe count", cap_a.size(), n);
    if (cap_a.size() == n) begin
      for (int i = 0; i < n; i++) begin
        chk(cap_a[i] == ea[i], req, "write strobe address", cap_a[i], ea[i]);
        chk(cap_d[i] == ed[i], req, "write strobe data", cap_d[i], ed[i]);
      end
    end
    exp_ptr = (n > 0) ? page_at(b, n) : b;
  endtask

  task automatic poll_ready(output int polls);
    bit a;
    polls = 0;
    do begin
      start_c(); xfer_byte(sel(1'b0), a); stop_c(); polls++;
    end while (!a && polls < 50);
  endtask

  task automatic do_read_cur(input int n, input string req);
    bit a;
    logic [7:0] d;
    start_c();
    xfer_byte(sel(1'b1), a);
    chk(a, req, "read select acknowledged", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, d);
      chk(d == exp_read(exp_ptr), req, $sformatf("read data at %0h", exp_ptr),
          int'(d), int'(exp_read(exp_ptr)));
      exp_ptr = (exp_ptr + 1) % MEM;
    end
    stop_c();
  endtask

  task automatic do_read_rand(input logic [15:0] wa, input int n, input string req);
    bit a, ok;
    ok = 1'b1;
    start_c();
    xfer_byte(sel(1'b0), a); ok &= a;
    xfer_byte(wa[15:8], a); ok &= a;
    xfer_byte(wa[7:0], a); ok &= a;
    chk(ok, req, "address phase acknowledged", int'(ok), 1);
    exp_ptr = int'(wa) & (MEM - 1);
    do_read_cur(n, req);
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (20) @(negedge clk);
    begin : main
      bit a;
      int c0, polls;
      logic [7:0] d;
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(sda_oe == 1'b0 && wr_valid == 1'b0 && wr_commit == 1'b0, "R1",
          "reset outputs idle", int'({sda_oe, wr_valid, wr_commit}), 0);

      // bus activity before any start is ignored
      xfer_byte(sel(1'b0), a);
      chk(!a, "R1", "no ack before first start", int'(a), 0);
      stop_c();

      // wrong strap bits, wrong prefix
      start_c(); xfer_byte({4'b1010, 3'b001, 1'b0}, a);
      chk(!a, "R2", "strap mismatch not acked", int'(a), 0);
      xfer_byte(8'h00, a);
      chk(!a, "R2", "bus ignored after mismatch", int'(a), 0);
      stop_c();
      start_c(); xfer_byte({4'b1011, STRAP, 1'b0}, a);
      chk(!a, "R2", "prefix mismatch not acked", int'(a), 0);
      stop_c();

      // write with don't-care upper address bits
      c0 = n_commit;
      do_write(16'hF123, 3, "R5");
      chk(n_commit == c0 + 1, "R7", "commit after data write", n_commit, c0 + 1);

      // busy: select refused, then accepted
      start_c(); xfer_byte(sel(1'b0), a);
      chk(!a, "R4", "select refused while busy", int'(a), 0);
      stop_c();
      poll_ready(polls);
      chk(polls > 1 && polls < 50, "R4", "ack polling ends after busy", polls, 2);
      chk(busy == 1'b0, "R4", "busy low when ack returned", int'(busy), 0);

      // current-address read after write continues the pointer
      do_read_rand(16'h0123, 3, "R9");
      do_read_cur(2, "R8");

      // in-page wrap of write addresses
      do_write(16'h045E, 5, "R6");
      poll_ready(polls);
      do_read_rand(16'h0440, 2, "R6");
      do_read_rand(16'h045E, 2, "R6");

      // dummy write produces no commit
      c0 = n_commit;
      do_read_rand(16'h0200, 1, "R9");
      chk(n_commit == c0, "R7", "no commit for address-only write", n_commit, c0);

      // sequential read wrapping at top of array
      do_read_rand(16'(MEM - 2), 5, "R10");

      // master NACK: bus ignored afterwards
      start_c(); xfer_byte(sel(1'b1), a);
      rd_byte(1'b0, d);
      chk(d == exp_read(exp_ptr), "R11", "single byte before nack", int'(d), int'(exp_read(exp_ptr)));
      exp_ptr = (exp_ptr + 1) % MEM;
      xfer_byte(sel(1'b0), a);
      chk(!a, "R11", "no ack after master nack", int'(a), 0);
      chk(sda_oe == 1'b0, "R11", "line released after nack", int'(sda_oe), 0);
      stop_c();

      // start in mid-byte aborts the address phase
      start_c(); xfer_byte(sel(1'b0), a); xfer_byte(8'h0F, a);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      start_c(); xfer_byte(sel(1'b1), a);
      chk(a, "R1", "select after abort acked", int'(a), 1);
      rd_byte(1'b0, d);
      chk(d == exp_read(exp_ptr), "R1", "pointer kept through abort", int'(d), int'(exp_read(exp_ptr)));
      exp_ptr = (exp_ptr + 1) % MEM;
      stop_c();

      // constrained random write / read-back
      for (int it = 0; it < 10; it++) begin
        logic [15:0] wa;
        int n;
        wa = 16'($urandom);
        n = 1 + int'($urandom % 6);
        do_write(wa, n, "R6");
        poll_ready(polls);
        if (it % 2 == 0) do_read_rand(wa, n + 2, "R10");
        else do_read_cur(2, "R8");
      end

      chk(r12_bad == 0, "R12", "pull-down changes with SCL high", r12_bad, 0);
    end
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule